// File: doc/BRIEF.md
# Software Interrupt Dispatcher

This block sits behind the write-only software interrupt trigger register of an interrupt distributor. When software on one CPU writes the register, the block decodes the word into an interrupt number, a routing mode and an optional explicit CPU list. It then raises "set pending" requests towards the per-CPU pending logic, which lives outside this block.

Each request carries three things: a one-cycle pulse for every targeted CPU, the 4-bit interrupt number, and a one-hot vector that names the CPU that made the request. That vector is OR-ed into the interrupt's source record downstream. The count of online CPUs (1 to 8) limits every target set. A read of the register returns zero.

Top module: `sgi_dispatch`

## Requirements
- R1: The interrupt number is write-data bits [3:0]. It appears on `sgi_id` in the cycle after the write edge, together with the pulses.
- R2: Routing mode is write-data bits [25:24]. Mode 0 targets the CPUs whose bits are set in write-data bits [23:16], where bit 16+i selects CPU i.
- R3: In any mode, no pulse is raised for a CPU index at or above `cpus_online`.
- R4: Mode 1 targets every online CPU except the requester `req_cpu`.
- R5: Mode 2 targets only the requester.
- R6: Mode 3 is reserved. Such a write raises no pulse, whatever the other fields hold.
- R7: While any pulse is high, `sgi_src` is one-hot with only bit `req_cpu` (as sampled at the write) set.
- R8: Every pulse of one write is issued in the same single cycle. A write whose resulting target set is empty raises no pulse, and no pulse appears without a write in the previous cycle.
- R9: `rd_data` reads as zero at all times.
- R10: While reset is asserted and in the first cycle after it, all pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the trigger register |
| wr_data | input | 32 | Write data word |
| req_cpu | input | 3 | Index of the CPU performing the write |
| cpus_online | input | 4 | Number of online CPUs, 1 to 8 |
| rd_data | output | 32 | Read data of the register, always zero |
| set_pulse | output | 8 | One-cycle set-pending request, one bit per CPU |
| sgi_id | output | 4 | Interrupt number of the current request |
| sgi_src | output | 8 | One-hot requester bit for the source record |

## Verification
The explicit-list mode is driven with a sparse list over all eight CPUs, with a full list under a reduced online count, and with an empty list. These separate correct bit mapping from missing online clipping and from spurious pulses. The broadcast mode is driven with the requester in the middle of the online range and with a single online CPU that is itself the requester. This shows whether self-exclusion and the empty-set case are handled. The self mode and the reserved mode, the latter carrying a full target list, show whether the mode field alone decides the routing. Varying interrupt numbers and requesters across cases exposes crossed ID or source fields.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  localparam int unsigned SGI_ID_W   = 4;
  localparam int unsigned SGI_LIST_W = 8;

  typedef enum logic [1:0] {
    RT_LIST   = 2'd0,
    RT_OTHERS = 2'd1,
    RT_SELF   = 2'd2,
    RT_RSVD   = 2'd3
  } route_e;

  typedef struct packed {
    logic [SGI_LIST_W-1:0] list;
    route_e                route;
    logic [SGI_ID_W-1:0]   id;
  } sgi_cmd_t;

  // Mask with the lowest n bits set.
  function automatic logic [SGI_LIST_W-1:0] low_mask(input int unsigned n);
    logic [SGI_LIST_W-1:0] m;
    for (int unsigned i = 0; i < SGI_LIST_W; i++) m[i] = (i < n);
    return m;
  endfunction

  // Single bit at position idx.
  function automatic logic [SGI_LIST_W-1:0] one_bit(input int unsigned idx);
    logic [SGI_LIST_W-1:0] m;
    for (int unsigned i = 0; i < SGI_LIST_W; i++) m[i] = (i == idx);
    return m;
  endfunction
endpackage

// File: rtl/sgi_cmd_decode.sv
module sgi_cmd_decode
  import sgi_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] wr_data,
  output sgi_cmd_t          cmd
);
  localparam int unsigned ID_LSB    = 0;
  localparam int unsigned LIST_LSB  = 16;
  localparam int unsigned ROUTE_LSB = 24;

  logic unused_fields;
  assign unused_fields = ^{wr_data[DATA_W-1:ROUTE_LSB+2],
                           wr_data[LIST_LSB-1:ID_LSB+SGI_ID_W]};

  always_comb begin
    cmd.id    = wr_data[ID_LSB +: SGI_ID_W];
    cmd.list  = wr_data[LIST_LSB +: SGI_LIST_W];
    cmd.route = route_e'(wr_data[ROUTE_LSB +: 2]);
  end
endmodule

// File: rtl/sgi_target_filter.sv
module sgi_target_filter
  import sgi_pkg::*;
#(
  parameter int unsigned NUM_CPUS = 8,
  localparam int unsigned IDX_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int unsigned CNT_W = $clog2(NUM_CPUS + 1)
) (
  input  sgi_cmd_t             cmd,
  input  logic [IDX_W-1:0]     req_cpu,
  input  logic [CNT_W-1:0]     cpus_online,
  output logic [NUM_CPUS-1:0]  tgt_mask,
  output logic                 rsvd_drop
);
  logic [SGI_LIST_W-1:0] online_w;
  logic [SGI_LIST_W-1:0] self_w;
  logic [SGI_LIST_W-1:0] raw_w;
  logic [SGI_LIST_W-1:0] clip_w;

  assign online_w  = low_mask(int'(cpus_online));
  assign self_w    = one_bit(int'(req_cpu));
  assign rsvd_drop = (cmd.route == RT_RSVD);

  always_comb begin
    unique case (cmd.route)
      RT_LIST:   raw_w = cmd.list;
      RT_OTHERS: raw_w = ~self_w;
      RT_SELF:   raw_w = self_w;
      default:   raw_w = '0;
    endcase
    clip_w = raw_w & online_w;
  end

  assign tgt_mask = clip_w[NUM_CPUS-1:0];
endmodule

// File: rtl/sgi_pulse_out.sv
module sgi_pulse_out
  import sgi_pkg::*;
#(
  parameter int unsigned NUM_CPUS = 8,
  localparam int unsigned IDX_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fire,
  input  logic [NUM_CPUS-1:0] tgt_mask,
  input  logic [SGI_ID_W-1:0] id_in,
  input  logic [IDX_W-1:0]    req_cpu,
  output logic [NUM_CPUS-1:0] set_pulse,
  output logic [SGI_ID_W-1:0] sgi_id,
  output logic [NUM_CPUS-1:0] sgi_src
);
  logic [SGI_LIST_W-1:0] src_w;
  assign src_w = one_bit(int'(req_cpu));

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    always_ff @(posedge clk) begin
      if (!rst_n) set_pulse[c] <= 1'b0;
      else        set_pulse[c] <= fire & tgt_mask[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sgi_id  <= '0;
      sgi_src <= '0;
    end else if (fire) begin
      sgi_id  <= id_in;
      sgi_src <= src_w[NUM_CPUS-1:0];
    end
  end
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
  import sgi_pkg::*;
#(
  parameter int unsigned NUM_CPUS = 8,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned IDX_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int unsigned CNT_W = $clog2(NUM_CPUS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [IDX_W-1:0]    req_cpu,
  input  logic [CNT_W-1:0]    cpus_online,
  output logic [DATA_W-1:0]   rd_data,
  output logic [NUM_CPUS-1:0] set_pulse,
  output logic [SGI_ID_W-1:0] sgi_id,
  output logic [NUM_CPUS-1:0] sgi_src
);
  sgi_cmd_t            cmd;
  logic [NUM_CPUS-1:0] tgt_mask;
  logic                rsvd_drop;
  logic                fire;

  // Write-only register: reads see zero.
  assign rd_data = '0;

  sgi_cmd_decode #(.DATA_W(DATA_W)) u_dec (
    .wr_data (wr_data),
    .cmd     (cmd)
  );

  sgi_target_filter #(.NUM_CPUS(NUM_CPUS)) u_flt (
    .cmd         (cmd),
    .req_cpu     (req_cpu),
    .cpus_online (cpus_online),
    .tgt_mask    (tgt_mask),
    .rsvd_drop   (rsvd_drop)
  );

  assign fire = wr_en & ~rsvd_drop;

  sgi_pulse_out #(.NUM_CPUS(NUM_CPUS)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .tgt_mask  (tgt_mask),
    .id_in     (cmd.id),
    .req_cpu   (req_cpu),
    .set_pulse (set_pulse),
    .sgi_id    (sgi_id),
    .sgi_src   (sgi_src)
  );

  // Reserved route drops the write (R6).
  p_rsvd_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[25:24] == 2'd3) |=> (set_pulse == '0));

  // Pulses only follow a write, one cycle later (R8).
  p_pulse_needs_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_pulse != '0) |-> $past(wr_en));

  // No pulse lasts two cycles without a second write (R8).
  p_single_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) |=> (set_pulse == '0));

  // Requester record is one-hot while requests are out (R7).
  p_src_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_pulse != '0) |-> ($countones(sgi_src) == 1));

  // ID accompanies the pulses (R1).
  p_id_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (set_pulse != '0) |-> (sgi_id == $past(wr_data[3:0])));

  // Broadcast never hits the requester (R4).
  p_self_excluded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[25:24] == 2'd1) |=>
      ((set_pulse & sgi_src) == '0));
endmodule

// File: tb/sgi_dispatch_tb.sv
module sgi_dispatch_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [2:0]  req_cpu;
  logic [3:0]  cpus_online;
  logic [31:0] rd_data;
  logic [7:0]  set_pulse;
  logic [3:0]  sgi_id;
  logic [7:0]  sgi_src;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sgi_dispatch u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .req_cpu(req_cpu), .cpus_online(cpus_online), .rd_data(rd_data),
    .set_pulse(set_pulse), .sgi_id(sgi_id), .sgi_src(sgi_src)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // Expected targets, written from the requirements.
  function automatic logic [7:0] want(input logic [31:0] d, input int req, input int n);
    logic [7:0] m = '0;
    for (int i = 0; i < 8; i++) begin
      if (i < n) begin
        case (d[25:24])
          2'd0: m[i] = d[16+i];
          2'd1: m[i] = (i != req);
          2'd2: m[i] = (i == req);
          default: m[i] = 1'b0;
        endcase
      end
    end
    return m;
  endfunction

  task automatic run_case(input string req, input logic [31:0] d, input int rq, input int n);
    logic [7:0] exp_m;
    exp_m = want(d, rq, n);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; req_cpu = 3'(rq); cpus_online = 4'(n);
    @(negedge clk);
    wr_en = 1'b0;
    chk({req, " targets"}, {24'h0, set_pulse}, {24'h0, exp_m});
    if (exp_m != 0) begin
      chk({req, " R1 id"}, {28'h0, sgi_id}, {28'h0, d[3:0]});
      chk({req, " R7 src"}, {24'h0, sgi_src}, 32'h1 << rq);
    end
    @(negedge clk);
    chk({req, " R8 one cycle"}, {24'h0, set_pulse}, 32'h0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; req_cpu = '0; cpus_online = 4'd8;
    repeat (3) @(negedge clk);
    chk("R10 in reset", {24'h0, set_pulse}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 after reset", {24'h0, set_pulse}, 32'h0);
    chk("R9 read zero", rd_data, 32'h0);
  endtask

  task automatic t_list();
    run_case("R2 sparse list", 32'h00A5_0003, 1, 8);
    run_case("R3 clipped list", 32'h00FF_000C, 0, 3);
    run_case("R8 empty list", 32'h0000_0007, 2, 8);
  endtask

  task automatic t_others();
    run_case("R4 others mid", 32'h0100_0009, 2, 4);
    run_case("R4 others lone", 32'h0100_0001, 0, 1);
  endtask

  task automatic t_self();
    run_case("R5 self", 32'h02FF_000F, 5, 8);
  endtask

  task automatic t_rsvd();
    run_case("R6 reserved", 32'h03FF_0004, 3, 8);
    chk("R9 read zero after writes", rd_data, 32'h0);
  endtask

  initial begin
    t_reset();
    t_list();
    t_others();
    t_self();
    t_rsvd();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule